// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller with RAS-Only Refresh

This block sits between a simple host port and a 16K x 1 dynamic RAM whose address pins are shared between row and column. The host presents a 14-bit address, a read/write flag and one data bit. The controller splits the address into a row half (low seven bits) and a column half (high seven bits), and puts each half on a 7-bit address bus in inverted form. A row-enable select chooses which half is on the bus. The active-low row and column strobes are sequenced around that select, so each half is stable when its strobe falls.

Dynamic cells lose their charge, so an internal timer counts system clocks for one refresh period. It derives that period from a clock-frequency parameter and a period-length parameter. When the period expires, the controller runs a burst of RAS-only cycles. A row counter walks all 128 rows in ascending order, and the column strobe stays high for the whole burst. A due refresh takes precedence over new host requests. A host cycle already under way runs to completion first. The host sees busy while any cycle is running and an ack pulse when its own cycle completes. A refresh burst is requested straight out of reset.

Top module: `dram_refresh_ctl`

## Requirements
- R1: While reset is asserted, and after it is released, the row strobe, column strobe and write enable are all high (inactive). The first bus activity after reset is a refresh cycle on row 0, and it begins within 6 clocks of the reset input going high.
- R2: Whenever the row strobe falls, row-enable is 1, and the address bus carries the bitwise inverse of address bits 6..0 of the cycle.
- R3: Whenever the column strobe falls, row-enable is 0, and the address bus carries the bitwise inverse of address bits 13..7.
- R4: A host cycle runs in this order: row address, row strobe low, column address, column strobe low. The column strobe is low only while the row strobe is low.
- R5: A write drives write-enable low (active) while the column strobe is low and presents the host data bit on the data output. A read keeps write-enable high, and the bit read from the DRAM appears on the host read-data port together with ack.
- R6: After every release of the row strobe, it stays high for at least one full clock before it falls again.
- R7: A refresh cycle pulses the row strobe while the column strobe stays high. Successive refresh cycles address rows 0, 1, ..., 127, then wrap to 0, so one burst covers all 128 rows.
- R8: Each row is refreshed again within the refresh period (clock kHz x period us / 1000 clocks) plus a few clocks of arbitration slack. A refresh that is due stays pending until its burst starts.
- R9: A refresh that is due is served before a waiting host request, so a request held from reset completes only after a full 128-row burst. Busy is high during every refresh cycle.
- R10: Each host cycle yields exactly one ack pulse, one clock wide, issued in the clock after the column strobe is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Host cycle request, held until ack |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 14 | Host address; bits 6..0 row, 13..7 column |
| host_wdata | input | 1 | Write data bit |
| host_rdata | output | 1 | Read data bit, valid with ack |
| host_ack | output | 1 | One-clock completion pulse |
| host_busy | output | 1 | A cycle (host or refresh) is running |
| dram_ma | output | 7 | Multiplexed address bus, inverted |
| dram_row_en | output | 1 | 1 = row half on bus, 0 = column half |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_dout | output | 1 | Data bit to the DRAM |
| dram_din | input | 1 | Data bit from the DRAM |

## Verification
The host side is exercised with three address sweeps, each written and then read back. The first walks all 128 rows under one fixed column. The second walks all 128 columns under one fixed row. The third uses a pseudo-random set that mixes both halves. A swapped, non-inverted or mis-sliced address half shows up either as a wrong captured row or column, or as wrong read data. Data is a parity function of the address, so a write that lands at the wrong location is caught on read-back. Refresh cycles are told apart from host cycles by the absence of a column strobe. Their row sequence and the interval between two visits to the same row are checked against the configured period. A request held from reset separates correct refresh priority from host-first arbitration.

// File: rtl/dram_ctl_pkg.sv
package dram_ctl_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_HROW,
    ST_HRAS,
    ST_HCOL,
    ST_HCAS,
    ST_HPRE,
    ST_RROW,
    ST_RRAS,
    ST_RPRE
  } seq_state_t;

endpackage

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
  parameter int unsigned PERIOD_CYC = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  output logic due
);
  localparam int unsigned CW = (PERIOD_CYC > 2) ? $clog2(PERIOD_CYC) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(PERIOD_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          due_q, due_d;
  logic          expire;

  assign expire = (cnt_q == '0);

  always_comb begin
    cnt_d = expire ? RELOAD : cnt_q - 1'b1;
    due_d = due_q;
    if (take)   due_d = 1'b0;
    if (expire) due_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= RELOAD;
      due_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      due_q <= due_d;
    end
  end

  assign due = due_q;

  // R8: a pending refresh is only dropped when its burst is taken
  assert_due_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (due && !take) |=> due);

endmodule

// File: rtl/dram_row_counter.sv
module dram_row_counter #(
  parameter int unsigned ROW_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [ROW_W-1:0] row,
  output logic             last
);
  logic [ROW_W-1:0] row_q, row_d;

  always_comb begin
    row_d = row_q;
    if (inc) row_d = row_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) row_q <= '0;
    else        row_q <= row_d;
  end

  assign row  = row_q;
  assign last = &row_q;

  // R7: refresh rows advance by exactly one per refresh cycle
  assert_row_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    inc |=> (row == $past(row) + 1'b1));

endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux #(
  parameter int unsigned ROW_W = 7
) (
  input  logic [ROW_W-1:0] row,
  input  logic [ROW_W-1:0] col,
  input  logic             row_en,
  output logic [ROW_W-1:0] ma
);
  for (genvar b = 0; b < ROW_W; b++) begin : g_bit
    assign ma[b] = row_en ? ~row[b] : ~col[b];
  end
endmodule

// File: rtl/dram_seq.sv
module dram_seq
  import dram_ctl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic wr,
  input  logic ref_due,
  input  logic last_row,
  output logic accept,
  output logic ref_take,
  output logic row_inc,
  output logic refreshing,
  output logic cap_rd,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic row_en,
  output logic ack,
  output logic busy
);
  seq_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (ref_due) st_d = ST_RROW;
               else if (req) st_d = ST_HROW;
      ST_HROW: st_d = ST_HRAS;
      ST_HRAS: st_d = ST_HCOL;
      ST_HCOL: st_d = ST_HCAS;
      ST_HCAS: st_d = ST_HPRE;
      ST_HPRE: st_d = ST_IDLE;
      ST_RROW: st_d = ST_RRAS;
      ST_RRAS: st_d = ST_RPRE;
      ST_RPRE: st_d = last_row ? ST_IDLE : ST_RROW;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_comb begin
    accept     = (st_q == ST_IDLE) && !ref_due && req;
    ref_take   = (st_q == ST_IDLE) && ref_due;
    row_inc    = (st_q == ST_RPRE);
    refreshing = (st_q == ST_RROW) || (st_q == ST_RRAS) || (st_q == ST_RPRE);
    cap_rd     = (st_q == ST_HCAS);
    ras_n      = !((st_q == ST_HRAS) || (st_q == ST_HCOL) ||
                   (st_q == ST_HCAS) || (st_q == ST_RRAS));
    cas_n      = !(st_q == ST_HCAS);
    we_n       = !((st_q == ST_HCAS) && wr);
    row_en     = !((st_q == ST_HCOL) || (st_q == ST_HCAS));
    ack        = (st_q == ST_HPRE);
    busy       = (st_q != ST_IDLE);
  end

  assert_cas_inside_ras_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> !ras_n);
  assert_row_at_ras_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> row_en);
  assert_col_at_cas_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> !row_en);
  assert_precharge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |=> ras_n);
  assert_refresh_no_cas_R7: assert property (@(posedge clk) disable iff (!rst_n)
    refreshing |-> cas_n);
  assert_ack_after_cas_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> $past(!cas_n));

endmodule

// File: rtl/dram_refresh_ctl.sv
module dram_refresh_ctl #(
  parameter int unsigned CLK_KHZ   = 125000,
  parameter int unsigned PERIOD_US = 2000,
  parameter int unsigned ROW_W     = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_req,
  input  logic               host_we,
  input  logic [2*ROW_W-1:0] host_addr,
  input  logic               host_wdata,
  output logic               host_rdata,
  output logic               host_ack,
  output logic               host_busy,
  output logic [ROW_W-1:0]   dram_ma,
  output logic               dram_row_en,
  output logic               dram_ras_n,
  output logic               dram_cas_n,
  output logic               dram_we_n,
  output logic               dram_dout,
  input  logic               dram_din
);
  localparam int unsigned ADDR_W     = 2 * ROW_W;
  localparam int unsigned PERIOD_CYC = CLK_KHZ * PERIOD_US / 1000;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  logic             accept, ref_take, row_inc, refreshing, cap_rd;
  logic             ref_due, last_row;
  logic [ROW_W-1:0] ref_row, row_src;

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              we_q, we_d, wd_q, wd_d, rd_q, rd_d;

  always_comb begin
    addr_d = addr_q;
    we_d   = we_q;
    wd_d   = wd_q;
    rd_d   = rd_q;
    if (accept) begin
      addr_d = host_addr;
      we_d   = host_we;
      wd_d   = host_wdata;
    end
    if (cap_rd && !we_q) rd_d = dram_din;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      addr_q <= '0;
      we_q   <= 1'b0;
      wd_q   <= 1'b0;
      rd_q   <= 1'b0;
    end else begin
      addr_q <= addr_d;
      we_q   <= we_d;
      wd_q   <= wd_d;
      rd_q   <= rd_d;
    end
  end

  dram_refresh_timer #(.PERIOD_CYC(PERIOD_CYC)) u_timer (
    .clk  (clk),
    .rst_n(rst_s),
    .take (ref_take),
    .due  (ref_due)
  );

  dram_row_counter #(.ROW_W(ROW_W)) u_rows (
    .clk  (clk),
    .rst_n(rst_s),
    .inc  (row_inc),
    .row  (ref_row),
    .last (last_row)
  );

  dram_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_s),
    .req       (host_req),
    .wr        (we_q),
    .ref_due   (ref_due),
    .last_row  (last_row),
    .accept    (accept),
    .ref_take  (ref_take),
    .row_inc   (row_inc),
    .refreshing(refreshing),
    .cap_rd    (cap_rd),
    .ras_n     (dram_ras_n),
    .cas_n     (dram_cas_n),
    .we_n      (dram_we_n),
    .row_en    (dram_row_en),
    .ack       (host_ack),
    .busy      (host_busy)
  );

  assign row_src = refreshing ? ref_row : addr_q[ROW_W-1:0];

  dram_addr_mux #(.ROW_W(ROW_W)) u_mux (
    .row   (row_src),
    .col   (addr_q[ADDR_W-1:ROW_W]),
    .row_en(dram_row_en),
    .ma    (dram_ma)
  );

  assign host_rdata = rd_q;
  assign dram_dout  = wd_q;

  // R5: write enable only falls together with the column strobe
  assert_we_in_cas_R5: assert property (@(posedge clk) disable iff (!rst_s)
    !dram_we_n |-> !dram_cas_n);

endmodule

// File: tb/dram_refresh_ctl_bench.sv
`timescale 1ns/1ps
module dram_refresh_ctl_bench;
  localparam int PERIOD_US = 8;
  localparam int CLK_KHZ   = 125000;
  localparam int PERIOD    = CLK_KHZ * PERIOD_US / 1000;
  localparam int NOPS      = 384;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_req = 1'b0, host_we = 1'b0, host_wdata = 1'b0;
  logic [13:0] host_addr = '0;
  logic        host_rdata, host_ack, host_busy;
  logic [6:0]  dram_ma;
  logic        dram_row_en, dram_ras_n, dram_cas_n, dram_we_n, dram_dout;
  logic        dram_din = 1'b0;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  int rel_cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dram_refresh_ctl #(.CLK_KHZ(CLK_KHZ), .PERIOD_US(PERIOD_US)) u_dram_refresh_ctl (
    .clk(clk), .rst_n(rst_n),
    .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_ack(host_ack),
    .host_busy(host_busy), .dram_ma(dram_ma), .dram_row_en(dram_row_en),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_dout(dram_dout), .dram_din(dram_din)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural DRAM model, sampled on falling clock edges
  logic      mem [int];
  logic      p_ras = 1'b1, p_cas = 1'b1;
  logic [6:0] cap_row, cap_col;
  bit        cap_ok = 0, saw_cas = 0, busy_at_fall = 0;
  int        hi_cnt = 1;
  int        exp_ref = 0;
  int        ref_total = 0;
  int        ref_before_host = -1;
  int        first_ras_cyc = -1;
  bit        first_ras_ref = 0;
  int        last_ref [128];

  initial for (int i = 0; i < 128; i++) last_ref[i] = -1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (p_ras && !dram_ras_n) begin
        check(dram_row_en == 1'b1, "R2 row_en at RAS fall", dram_row_en, 1);
        check(hi_cnt >= 1, "R6 precharge clocks", hi_cnt, 1);
        cap_row = ~dram_ma;
        saw_cas = 0;
        busy_at_fall = host_busy;
        if (first_ras_cyc < 0) begin
          first_ras_cyc = cyc;
          first_ras_ref = dram_cas_n;
        end
      end
      if (!dram_cas_n) begin
        check(!dram_ras_n, "R4 CAS low inside RAS low", dram_ras_n, 0);
      end
      if (p_cas && !dram_cas_n) begin
        check(dram_row_en == 1'b0, "R3 row_en at CAS fall", dram_row_en, 0);
        cap_col = ~dram_ma;
        saw_cas = 1;
        cap_ok = 1;
        if (ref_before_host < 0) ref_before_host = ref_total;
        if (!dram_we_n) mem[{cap_col, cap_row}] = dram_dout;
        else dram_din = mem.exists({cap_col, cap_row}) ? mem[{cap_col, cap_row}] : 1'b0;
      end
      if (!p_ras && dram_ras_n && !saw_cas) begin
        check(int'(cap_row) == exp_ref, "R7 refresh row order", cap_row, exp_ref);
        check(busy_at_fall, "R9 busy during refresh", busy_at_fall, 1);
        if (last_ref[cap_row] >= 0)
          check((cyc - last_ref[cap_row] <= PERIOD + 8) &&
                (cyc - last_ref[cap_row] >= PERIOD - 8),
                "R8 refresh interval", cyc - last_ref[cap_row], PERIOD);
        last_ref[cap_row] = cyc;
        exp_ref = (exp_ref + 1) % 128;
        ref_total++;
      end
      hi_cnt = dram_ras_n ? hi_cnt + 1 : 0;
      p_ras = dram_ras_n;
      p_cas = dram_cas_n;
    end
  end

  function automatic logic [13:0] addr_of(input int i);
    logic [31:0] x;
    if (i < 128) return {7'h2A, 7'(i)};
    if (i < 256) return {7'(i - 128), 7'h15};
    x = 32'h1234_5678;
    for (int k = 0; k < i - 255; k++) x = x * 32'd1103515245 + 32'd12345;
    return x[23:10];
  endfunction

  function automatic logic data_of(input logic [13:0] a);
    return ^(a & 14'h2B5D) ^ a[0];
  endfunction

  task automatic host_op(input logic w, input logic [13:0] a, input logic d,
                         output logic q);
    @(negedge clk);
    cap_ok = 0;
    host_req = 1'b1; host_we = w; host_addr = a; host_wdata = d;
    do @(negedge clk); while (!host_ack);
    q = host_rdata;
    host_req = 1'b0;
    check(cap_ok && cap_row == a[6:0], "R2 row half", cap_row, a[6:0]);
    check(cap_ok && cap_col == a[13:7], "R3 column half", cap_col, a[13:7]);
    @(negedge clk);
    check(!host_ack, "R10 ack one clock", host_ack, 0);
  endtask

  initial begin
    logic q;
    repeat (3) @(negedge clk);
    check(dram_ras_n && dram_cas_n && dram_we_n, "R1 strobes idle in reset",
          {dram_ras_n, dram_cas_n, dram_we_n}, 7);
    check(!host_ack, "R1 no ack in reset", host_ack, 0);
    rst_n = 1'b1;
    rel_cyc = cyc;
    // request held from reset: must wait for the whole burst (R9)
    host_op(1'b1, 14'h1555, 1'b1, q);
    check(ref_before_host == 128, "R9 burst before host", ref_before_host, 128);
    check(first_ras_ref == 1'b1, "R1 first cycle is refresh", first_ras_ref, 1);
    check(first_ras_cyc - rel_cyc <= 6, "R1 refresh starts promptly",
          first_ras_cyc - rel_cyc, 6);
    host_op(1'b0, 14'h1555, 1'b0, q);
    check(q == 1'b1, "R5 read after first write", q, 1);
    for (int i = 0; i < NOPS; i++) host_op(1'b1, addr_of(i), data_of(addr_of(i)), q);
    for (int i = 0; i < NOPS; i++) begin
      host_op(1'b0, addr_of(i), 1'b0, q);
      check(q == data_of(addr_of(i)), "R5 read data", q, data_of(addr_of(i)));
    end
    // second write value to one location to see both polarities
    host_op(1'b1, 14'h0000, 1'b1, q);
    host_op(1'b0, 14'h0000, 1'b0, q);
    check(q == 1'b1, "R5 overwrite", q, 1);
    host_op(1'b1, 14'h0000, 1'b0, q);
    host_op(1'b0, 14'h0000, 1'b1, q);
    check(q == 1'b0, "R5 overwrite zero", q, 0);
    // let several refresh periods run idle
    repeat (3 * PERIOD) @(negedge clk);
    check(ref_total >= 4 * 128, "R8 bursts keep coming", ref_total, 4 * 128);
    check(dram_cas_n && dram_we_n, "R7 idle strobes", {dram_cas_n, dram_we_n}, 3);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule